// File: doc/BRIEF.md
# Ternary Ferroelectric Cell Access Sequencer

This block is a synchronous controller that runs one complete access to a row of single-transistor, single-capacitor ferroelectric cells. Each cell holds one of three levels: low (L), middle (M, a depolarized film) or high (H). For every access the sequencer produces the bit-line precharge control, the decoded word line, the plate-line pulse, a four-way bit-line drive select and the sense-amplifier strobes. It takes in the results of a single shared comparator, which checks the cell signal first against a low reference and then against a high reference. It returns the two-bit level code that it sensed.

Sensing destroys the stored state, so every access ends with a write-back phase. A read restores the level that was sensed. A write stores the newly supplied level instead. L and H are restored with two plate and bit-line steps. M needs an erase step, a release step, a partial drive of the bit line to an intermediate voltage and a final release. Every phase lasts a number of clock cycles set by a parameter, so that analog settling times can be met. Requests are taken only while the block is idle. A one-cycle done pulse marks the end of each access.

Top module: `tfe_seq`

## Requirements
- R1: An accepted request starts with the precharge phase: `pre_en` is high for T_PRE cycles, beginning the cycle after acceptance. During this phase no word line is active, the plate is low and the bit line is undriven.
- R2: After precharge, only the word line of the addressed row (`wl[row]`, one-hot) rises, for T_WL cycles with the plate low. The plate line then rises and stays high for T_PL cycles before sensing begins. The plate is never high while no word line is active.
- R3: Sensing is sequential. A low-reference phase (`sa_ref_hi`=0) is followed by a high-reference phase (`sa_ref_hi`=1). Each lasts T_SA cycles with the plate high, and `sa_strobe` is high only in the last cycle of each phase, which is when the comparator is sampled.
- R4: Level decode from the two sampled comparator results: high-reference result 1 gives H (2'b10), whatever the low result is. Otherwise, low-reference result 1 gives M (2'b01), and both 0 gives L (2'b00). The code appears on `rd_level` in the done cycle and is held until the next access.
- R5: The write-back target is the sensed level for a read, and `req_data` captured at acceptance for a write.
- R6: Target L: the bit line is driven to 0 V (`bl_sel`=2'b01) for T_WB cycles with the plate high, then for T_WB cycles with the plate low.
- R7: Target H: the bit line is driven to VDD (`bl_sel`=2'b10) for T_WB cycles with the plate high, then for T_WB cycles with the plate low.
- R8: Target M: four steps in order. First, 0 V with the plate high (T_WB). Second, 0 V with the plate low (T_WB). Third, VM (`bl_sel`=2'b11) with the plate low (T_VM). Fourth, 0 V with the plate low (T_WB).
- R9: The `bl_sel` encoding is 2'b00 undriven, 2'b01 0 V, 2'b10 VDD, 2'b11 VM. The bit line is undriven whenever `pre_en` is high.
- R10: After write-back, all word lines are low and the plate is low while the bit line is held at 0 V for T_CL cycles. Then follows one cycle with `done`=1, all word lines low, the plate low and the bit line undriven. `busy` is high from the first precharge cycle through the done cycle.
- R11: A request is taken only when `busy` is low. `req_valid` during an access, including its done cycle, is ignored and does not start or extend an access.
- R12: An idle request with `req_write`=1 and `req_data`=2'b11 is rejected. `wr_err` is high for exactly the next cycle and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Addressed row |
| req_data | input | 2 | Level code to write |
| cmp_lo | input | 1 | Comparator: cell above low reference |
| cmp_hi | input | 1 | Comparator: cell above high reference |
| pre_en | output | 1 | Bit-line precharge to 0 V |
| wl | output | ROWS | Decoded word lines |
| pl_hi | output | 1 | Plate line at VDD |
| bl_sel | output | 2 | Bit-line drive target select |
| sa_strobe | output | 1 | Sense-amplifier strobe |
| sa_ref_hi | output | 1 | Reference select: 1 = high reference |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| wr_err | output | 1 | Illegal write data rejected |
| rd_level | output | 2 | Sensed level code |

## Verification
A new request can arrive in the same cycle as the done pulse of the previous access, and an illegal write can arrive while an access is still in progress. In both cases the acceptance logic and the sequencing logic meet in one cycle. The bench holds `req_valid` high across a done pulse. It expects one idle cycle, then a fresh precharge, and a second complete sequence with the level just written being sensed. It also offers both a legal and an illegal write in the middle of a running access. There it expects no error pulse, no change to the running sequence, and no extra access afterwards. Every output is compared against the behavioural model on every clock.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_WLON,
        PH_PLUP,
        PH_SNS_LO,
        PH_SNS_HI,
        PH_WB_A,
        PH_WB_B,
        PH_WB_VM,
        PH_WB_REL,
        PH_CLOSE,
        PH_DONE
    } phase_e;

    localparam logic [1:0] LVL_L   = 2'b00;
    localparam logic [1:0] LVL_M   = 2'b01;
    localparam logic [1:0] LVL_H   = 2'b10;
    localparam logic [1:0] LVL_BAD = 2'b11;

    localparam logic [1:0] BL_FLOAT = 2'b00;
    localparam logic [1:0] BL_ZERO  = 2'b01;
    localparam logic [1:0] BL_VDD   = 2'b10;
    localparam logic [1:0] BL_VM    = 2'b11;

endpackage

// File: rtl/tfe_level_dec.sv
module tfe_level_dec (
    input  logic       above_lo,
    input  logic       above_hi,
    output logic [1:0] level
);
    always_comb begin
        if (above_hi)
            level = tfe_pkg::LVL_H;
        else if (above_lo)
            level = tfe_pkg::LVL_M;
        else
            level = tfe_pkg::LVL_L;
    end
endmodule

// File: rtl/tfe_row_dec.sv
module tfe_row_dec #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3
) (
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  wl
);
    for (genvar g = 0; g < ROWS; g++) begin : g_line
        assign wl[g] = en && (row == ROW_W'(g));
    end
endmodule

// File: rtl/tfe_drive_map.sv
module tfe_drive_map (
    input  tfe_pkg::phase_e ph,
    input  logic [1:0]      tgt,
    input  logic            cnt_zero,
    output logic            pre_en,
    output logic            wl_on,
    output logic            pl_hi,
    output logic [1:0]      bl_sel,
    output logic            sa_strobe,
    output logic            sa_ref_hi,
    output logic            busy,
    output logic            done
);
    import tfe_pkg::*;

    logic [1:0] wb_lvl;

    assign wb_lvl = (tgt == LVL_H) ? BL_VDD : BL_ZERO;

    always_comb begin
        pre_en    = 1'b0;
        wl_on     = 1'b0;
        pl_hi     = 1'b0;
        bl_sel    = BL_FLOAT;
        sa_strobe = 1'b0;
        sa_ref_hi = 1'b0;
        done      = 1'b0;
        busy      = (ph != PH_IDLE);
        case (ph)
            PH_PRE:    pre_en = 1'b1;
            PH_WLON:   wl_on  = 1'b1;
            PH_PLUP: begin
                wl_on = 1'b1;
                pl_hi = 1'b1;
            end
            PH_SNS_LO: begin
                wl_on     = 1'b1;
                pl_hi     = 1'b1;
                sa_strobe = cnt_zero;
            end
            PH_SNS_HI: begin
                wl_on     = 1'b1;
                pl_hi     = 1'b1;
                sa_strobe = cnt_zero;
                sa_ref_hi = 1'b1;
            end
            PH_WB_A: begin
                wl_on  = 1'b1;
                pl_hi  = 1'b1;
                bl_sel = wb_lvl;
            end
            PH_WB_B: begin
                wl_on  = 1'b1;
                bl_sel = wb_lvl;
            end
            PH_WB_VM: begin
                wl_on  = 1'b1;
                bl_sel = BL_VM;
            end
            PH_WB_REL: begin
                wl_on  = 1'b1;
                bl_sel = BL_ZERO;
            end
            PH_CLOSE:  bl_sel = BL_ZERO;
            PH_DONE:   done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tfe_ctrl.sv
module tfe_ctrl #(
    parameter int ROW_W = 3,
    parameter int T_PRE = 3,
    parameter int T_WL  = 2,
    parameter int T_PL  = 3,
    parameter int T_SA  = 2,
    parameter int T_WB  = 3,
    parameter int T_VM  = 4,
    parameter int T_CL  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [1:0]       req_data,
    input  logic             cmp_lo,
    input  logic [1:0]       lvl_in,
    output tfe_pkg::phase_e  ph,
    output logic             cnt_zero,
    output logic [ROW_W-1:0] row,
    output logic [1:0]       tgt,
    output logic             lo_q,
    output logic [1:0]       rd_level,
    output logic             wr_err
);
    import tfe_pkg::*;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_MAX = max2(max2(max2(T_PRE, T_WL), max2(T_PL, T_SA)),
                                max2(max2(T_WB, T_VM), T_CL));
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic             wr;
        logic [1:0]       wdat;
        logic             lo;
        logic [1:0]       rd;
        logic [1:0]       tgt;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [CNT_W-1:0] dur(phase_e p);
        case (p)
            PH_PRE:    return CNT_W'(T_PRE - 1);
            PH_WLON:   return CNT_W'(T_WL - 1);
            PH_PLUP:   return CNT_W'(T_PL - 1);
            PH_SNS_LO: return CNT_W'(T_SA - 1);
            PH_SNS_HI: return CNT_W'(T_SA - 1);
            PH_WB_A:   return CNT_W'(T_WB - 1);
            PH_WB_B:   return CNT_W'(T_WB - 1);
            PH_WB_VM:  return CNT_W'(T_VM - 1);
            PH_WB_REL: return CNT_W'(T_WB - 1);
            PH_CLOSE:  return CNT_W'(T_CL - 1);
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_write && req_data == LVL_BAD) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.ph   = PH_PRE;
                        s_d.cnt  = dur(PH_PRE);
                        s_d.row  = req_row;
                        s_d.wr   = req_write;
                        s_d.wdat = req_data;
                    end
                end
            end
            PH_DONE: s_d.ph = PH_IDLE;
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    case (s_q.ph)
                        PH_PRE:    s_d.ph = PH_WLON;
                        PH_WLON:   s_d.ph = PH_PLUP;
                        PH_PLUP:   s_d.ph = PH_SNS_LO;
                        PH_SNS_LO: begin
                            s_d.lo = cmp_lo;
                            s_d.ph = PH_SNS_HI;
                        end
                        PH_SNS_HI: begin
                            s_d.rd  = lvl_in;
                            s_d.tgt = s_q.wr ? s_q.wdat : lvl_in;
                            s_d.ph  = PH_WB_A;
                        end
                        PH_WB_A:   s_d.ph = PH_WB_B;
                        PH_WB_B:   s_d.ph = (s_q.tgt == LVL_M) ? PH_WB_VM : PH_CLOSE;
                        PH_WB_VM:  s_d.ph = PH_WB_REL;
                        PH_WB_REL: s_d.ph = PH_CLOSE;
                        PH_CLOSE:  s_d.ph = PH_DONE;
                        default:   s_d.ph = PH_IDLE;
                    endcase
                    s_d.cnt = dur(s_d.ph);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ph       = s_q.ph;
    assign cnt_zero = (s_q.cnt == '0);
    assign row      = s_q.row;
    assign tgt      = s_q.tgt;
    assign lo_q     = s_q.lo;
    assign rd_level = s_q.rd;
    assign wr_err   = s_q.err;
endmodule

// File: rtl/tfe_seq.sv
module tfe_seq #(
    parameter int ROWS  = 8,
    parameter int T_PRE = 3,
    parameter int T_WL  = 2,
    parameter int T_PL  = 3,
    parameter int T_SA  = 2,
    parameter int T_WB  = 3,
    parameter int T_VM  = 4,
    parameter int T_CL  = 2,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [1:0]       req_data,
    input  logic             cmp_lo,
    input  logic             cmp_hi,
    output logic             pre_en,
    output logic [ROWS-1:0]  wl,
    output logic             pl_hi,
    output logic [1:0]       bl_sel,
    output logic             sa_strobe,
    output logic             sa_ref_hi,
    output logic             busy,
    output logic             done,
    output logic             wr_err,
    output logic [1:0]       rd_level
);
    tfe_pkg::phase_e  ph;
    logic             cnt_zero;
    logic [ROW_W-1:0] row;
    logic [1:0]       tgt;
    logic             lo_q;
    logic [1:0]       lvl;
    logic             wl_on;

    tfe_ctrl #(
        .ROW_W(ROW_W), .T_PRE(T_PRE), .T_WL(T_WL), .T_PL(T_PL),
        .T_SA(T_SA), .T_WB(T_WB), .T_VM(T_VM), .T_CL(T_CL)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_row  (req_row),
        .req_data (req_data),
        .cmp_lo   (cmp_lo),
        .lvl_in   (lvl),
        .ph       (ph),
        .cnt_zero (cnt_zero),
        .row      (row),
        .tgt      (tgt),
        .lo_q     (lo_q),
        .rd_level (rd_level),
        .wr_err   (wr_err)
    );

    tfe_level_dec i_lvl (
        .above_lo(lo_q),
        .above_hi(cmp_hi),
        .level   (lvl)
    );

    tfe_drive_map i_drv (
        .ph       (ph),
        .tgt      (tgt),
        .cnt_zero (cnt_zero),
        .pre_en   (pre_en),
        .wl_on    (wl_on),
        .pl_hi    (pl_hi),
        .bl_sel   (bl_sel),
        .sa_strobe(sa_strobe),
        .sa_ref_hi(sa_ref_hi),
        .busy     (busy),
        .done     (done)
    );

    tfe_row_dec #(.ROWS(ROWS), .ROW_W(ROW_W)) i_rows (
        .en (wl_on),
        .row(row),
        .wl (wl)
    );
endmodule

// File: rtl/tfe_seq_chk.sv
module tfe_seq_chk #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [ROW_W-1:0] req_row,
    input logic [1:0]       req_data,
    input logic             pre_en,
    input logic [ROWS-1:0]  wl,
    input logic             pl_hi,
    input logic [1:0]       bl_sel,
    input logic             sa_strobe,
    input logic             busy,
    input logic             done,
    input logic             wr_err
);
    logic unused_row;
    assign unused_row = ^req_row;

    assert_start_pre_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pre_en);

    assert_wl_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl));

    assert_plate_needs_wl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pl_hi |-> (wl != '0));

    assert_strobe_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sa_strobe |-> (pl_hi && wl != '0 && bl_sel == 2'b00));

    assert_vm_plate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bl_sel == 2'b11) |-> (!pl_hi && wl != '0));

    assert_pre_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (bl_sel == 2'b00 && wl == '0 && !pl_hi));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wl == '0 && !pl_hi && bl_sel == 2'b00 && busy));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && !busy));

    assert_err_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req_valid && req_write && req_data == 2'b11 && !busy));

    assert_err_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !busy);
endmodule

bind tfe_seq tfe_seq_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) i_tfe_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_row  (req_row),
    .req_data (req_data),
    .pre_en   (pre_en),
    .wl       (wl),
    .pl_hi    (pl_hi),
    .bl_sel   (bl_sel),
    .sa_strobe(sa_strobe),
    .busy     (busy),
    .done     (done),
    .wr_err   (wr_err)
);

// File: tb/test_tfe_seq.sv
`timescale 1ns/1ps
module test_tfe_seq;
    localparam int ROWS = 8;
    localparam int ROW_W = 3;
    localparam int T_PRE = 3, T_WL = 2, T_PL = 3, T_SA = 2;
    localparam int T_WB = 3, T_VM = 4, T_CL = 2;
    localparam int VW = ROWS + 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [1:0] req_data = '0;
    logic cmp_lo = 1'b0, cmp_hi = 1'b0;
    logic pre_en, pl_hi, sa_strobe, sa_ref_hi, busy, done, wr_err;
    logic [ROWS-1:0] wl;
    logic [1:0] bl_sel, rd_level;

    always #5 clk = ~clk;

    tfe_seq #(.ROWS(ROWS), .T_PRE(T_PRE), .T_WL(T_WL), .T_PL(T_PL), .T_SA(T_SA),
              .T_WB(T_WB), .T_VM(T_VM), .T_CL(T_CL)) i_tfe_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_data(req_data), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .pre_en(pre_en), .wl(wl), .pl_hi(pl_hi), .bl_sel(bl_sel),
        .sa_strobe(sa_strobe), .sa_ref_hi(sa_ref_hi), .busy(busy), .done(done),
        .wr_err(wr_err), .rd_level(rd_level)
    );

    typedef struct {
        logic [VW-1:0] v;
        logic          chk;
        logic [1:0]    rd;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    int cur_row = 0;
    bit finished = 0;
    logic [1:0] model [ROWS];

    function automatic logic [1:0] sense(logic lo, logic hi);
        if (hi) return 2'b10;
        if (lo) return 2'b01;
        return 2'b00;
    endfunction

    function automatic void push(int n, logic pre, logic wlon, logic pl, logic [1:0] bl,
                                 logic stbl, logic rhi, logic dn, logic chk,
                                 logic [1:0] rd, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic [ROWS-1:0] w;
            w = wlon ? (ROWS'(1) << cur_row) : '0;
            e.v = {pre, w, pl, bl, stbl && (i == n - 1), rhi, 1'b1, dn, 1'b0};
            e.chk = chk;
            e.rd = rd;
            e.tag = tag;
            q.push_back(e);
        end
    endfunction

    function automatic void push_idle(logic err, string tag);
        exp_t e;
        e.v = '0;
        e.v[0] = err;
        e.chk = 1'b0;
        e.rd = 2'b00;
        e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic void push_seq(int r, logic w, logic [1:0] d, logic [1:0] s);
        logic [1:0] t;
        string wt;
        cur_row = r;
        t = w ? d : s;
        wt = (t == 2'b00) ? "R5 R6" : (t == 2'b01) ? "R5 R8" : "R5 R7";
        push(T_PRE, 1, 0, 0, 2'b00, 0, 0, 0, 0, 0, "R1 R9");
        push(T_WL,  0, 1, 0, 2'b00, 0, 0, 0, 0, 0, "R2");
        push(T_PL,  0, 1, 1, 2'b00, 0, 0, 0, 0, 0, "R2");
        push(T_SA,  0, 1, 1, 2'b00, 1, 0, 0, 0, 0, "R3");
        push(T_SA,  0, 1, 1, 2'b00, 1, 1, 0, 0, 0, "R3");
        if (t == 2'b10) begin
            push(T_WB, 0, 1, 1, 2'b10, 0, 0, 0, 0, 0, wt);
            push(T_WB, 0, 1, 0, 2'b10, 0, 0, 0, 0, 0, wt);
        end else begin
            push(T_WB, 0, 1, 1, 2'b01, 0, 0, 0, 0, 0, wt);
            push(T_WB, 0, 1, 0, 2'b01, 0, 0, 0, 0, 0, wt);
            if (t == 2'b01) begin
                push(T_VM, 0, 1, 0, 2'b11, 0, 0, 0, 0, 0, wt);
                push(T_WB, 0, 1, 0, 2'b01, 0, 0, 0, 0, 0, wt);
            end
        end
        push(T_CL, 0, 0, 0, 2'b01, 0, 0, 0, 0, 0, "R10");
        push(1,    0, 0, 0, 2'b00, 0, 0, 1, 1, s, "R10");
        model[r] = t;
    endfunction

    task automatic compare();
        exp_t e;
        logic [VW-1:0] act;
        act = {pre_en, wl, pl_hi, bl_sel, sa_strobe, sa_ref_hi, busy, done, wr_err};
        if (q.size() > 0) begin
            e = q.pop_front();
        end else begin
            e.v = '0; e.chk = 0; e.rd = 0; e.tag = "R11";
        end
        checks++;
        if (act !== e.v) begin
            failures++;
            $display("FAIL %s: outputs act=%h exp=%h at %0t", e.tag, act, e.v, $time);
        end
        if (e.chk) begin
            checks++;
            if (rd_level !== e.rd) begin
                failures++;
                $display("FAIL R4: rd_level act=%b exp=%b", rd_level, e.rd);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic do_req_p(int r, logic w, logic [1:0] d, logic lo, logic hi);
        cmp_lo = lo; cmp_hi = hi;
        req_valid = 1; req_write = w; req_row = ROW_W'(r); req_data = d;
        push_seq(r, w, d, sense(lo, hi));
        step();
        req_valid = 0;
        drain();
    endtask

    task automatic do_req(int r, logic w, logic [1:0] d);
        do_req_p(r, w, d, model[r] != 2'b00, model[r] == 2'b10);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL R11: watchdog expired act=hung exp=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ROWS; i++) model[i] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare();

        // R5 R6 R7 R8: writes of each level
        do_req(0, 1, 2'b01);
        do_req(1, 1, 2'b10);
        do_req(2, 1, 2'b00);
        // R4 R5: reads return and restore stored level
        do_req(0, 0, 2'b00);
        do_req(1, 0, 2'b00);
        do_req(2, 0, 2'b00);
        do_req(0, 0, 2'b00);
        do_req(1, 1, 2'b01);
        do_req(1, 0, 2'b00);

        // R12: illegal write data rejected, no access starts
        req_valid = 1; req_write = 1; req_row = 3; req_data = 2'b11;
        push_idle(1, "R12");
        step();
        req_valid = 0;
        push_idle(0, "R12");
        step();
        do_req(3, 0, 2'b00);

        // R4: comparator pairs, high result has priority
        do_req_p(4, 0, 2'b00, 1'b0, 1'b1);
        do_req_p(5, 0, 2'b00, 1'b1, 1'b0);

        // R11: requests during a running access are ignored
        cmp_lo = 0; cmp_hi = 0;
        req_valid = 1; req_write = 0; req_row = 2; req_data = 0;
        push_seq(2, 0, 2'b00, 2'b00);
        step();
        req_write = 1; req_row = 5; req_data = 2'b10;
        repeat (4) step();
        req_data = 2'b11;
        repeat (4) step();
        req_valid = 0;
        drain();

        // R11 R10: request held across done, accepted after one idle cycle
        cmp_lo = 0; cmp_hi = 0;
        req_valid = 1; req_write = 1; req_row = 6; req_data = 2'b10;
        push_seq(6, 1, 2'b10, 2'b00);
        step();
        while (q.size() > 0) step();
        push_idle(0, "R11");
        cmp_lo = 1; cmp_hi = 1;
        push_seq(6, 1, 2'b10, 2'b10);
        step();
        step();
        req_valid = 0;
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule